// File: doc/BRIEF.md
# Two-Lane Extended-Data-Out DRAM Control Decoder

This block is a clocked model of the control logic inside an asynchronous DRAM that has two byte lanes. On every system clock it samples the active-low row strobe, the two lane column strobes, the write enable and the output enable. It then decides, for each lane, whether the access is a read, an early write or a late write (read-modify-write). The results drive per-lane write strobes into a small internal word store and per-lane drive enables for a 16-bit data bus. The bus is split into an input word and an output word plus a two-bit drive enable. A chip-level tristate pad would merge these into one bidirectional bus.

The row address is taken when the row strobe falls. The column address is taken on the first column strobe to fall. The store is addressed by the row bits followed by the column bits. Read data stays on the bus after a column strobe rises, which is the extended-data-out behaviour. The output enable alone can move a lane between driving and high impedance. A late write attempted while the output enable is asserted is dropped. If one lane starts an early write in the same cycle that the other lane makes a late write, the cycle is illegal: both writes are blocked and a sticky error flag is set.

Top module: `edo_lane_ctrl`

## Requirements
- R1: After synchronous reset, `dq_oe` is 00 and `mix_err` is 0.
- R2: When a lane's column strobe falls with `we_n` high, the access is a read. While `oe_n` is low and `ras_n` is low, that lane drives the addressed store byte on `dq_out` and sets its `dq_oe` bit. Bit 0 is the low lane, bit 1 the high lane.
- R3: After the column strobes of a read rise, the lane keeps driving the same data while `ras_n` and `oe_n` stay low and `we_n` stays high.
- R4: With `ras_n` low during a read, driving `oe_n` high clears the lane's `dq_oe` bit. Driving it low again restores the bit and the data. This holds whether the column strobe is high or low.
- R5: If `we_n` is already low when a lane's column strobe falls, the access is an early write. The byte on `dq_in` at that fall is written. The lane's `dq_oe` bit stays 0 even with `oe_n` low.
- R6: If `we_n` falls while a lane's column strobe is low in a read and `oe_n` is high, the access is a late write. The `dq_in` byte present at the `we_n` fall is written, not the byte present at the column fall.
- R7: A late write attempted while `oe_n` is low writes nothing. The lane keeps driving the stored byte.
- R8: `ras_n` going high clears both `dq_oe` bits. `we_n` falling during a read while the lane's column strobe is high also clears that lane's bit.
- R9: The row address is latched when `ras_n` falls. The column address is latched when the first of `casl_n`/`cash_n` falls. The store word index is {row, column}, with the row in the upper bits. Distinct (row, column) pairs hold independent words.
- R10: `casl_n` controls `dq_in`/`dq_out` bits 7:0 and `cash_n` controls bits 15:8. A write through one lane leaves the other lane's byte of the same word unchanged.
- R11: An early write on one lane in the same cycle as a late write on the other writes neither lane. It also sets `mix_err`, which stays 1 until reset. `mix_err` stays 0 for legal accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the strobes |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| casl_n | input | 1 | Low-lane column strobe, active low |
| cash_n | input | 1 | High-lane column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the bus |
| dq_out | output | 16 | Read data toward the bus |
| dq_oe | output | 2 | Per-lane drive enable (bit 0 low lane) |
| mix_err | output | 1 | Sticky illegal mixed-mode flag |

## Verification
The assertions assume that every pin level is held for at least two clocks, so each strobe edge is seen as a clean single-sample transition. They also assume that no column strobe falls unless the row strobe is already low and stable. The bench drives every pin change on the falling clock edge and holds it for four clocks. It always lowers the row strobe one step before any column strobe. Each access is closed by raising all strobes together, so no edge falls between samples.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [1:0] {
    LM_IDLE  = 2'd0,
    LM_READ  = 2'd1,
    LM_EARLY = 2'd2,
    LM_LATE  = 2'd3
  } lane_mode_e;
endpackage

// File: rtl/edo_pin_sampler.sv
module edo_pin_sampler #(
  parameter int LANES  = 2,
  parameter int ADDR_W = 4,
  parameter int DQ_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic [LANES-1:0]  cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic              ras_lo,
  output logic              ras_fall,
  output logic [LANES-1:0]  cas_lo,
  output logic [LANES-1:0]  cas_fall,
  output logic [LANES-1:0]  cas_rise,
  output logic              col_first,
  output logic              we_lo,
  output logic              we_fall,
  output logic              oe_lo,
  output logic [ADDR_W-1:0] s_addr,
  output logic [DQ_W-1:0]   s_dq
);
  // first stage: current sample, second stage: previous sample
  logic             s_ras, p_ras, s_we, p_we, s_oe;
  logic [LANES-1:0] s_cas, p_cas;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ras  <= 1'b1;
      p_ras  <= 1'b1;
      s_cas  <= '1;
      p_cas  <= '1;
      s_we   <= 1'b1;
      p_we   <= 1'b1;
      s_oe   <= 1'b1;
      s_addr <= '0;
      s_dq   <= '0;
    end else begin
      s_ras  <= ras_n;
      p_ras  <= s_ras;
      s_cas  <= cas_n;
      p_cas  <= s_cas;
      s_we   <= we_n;
      p_we   <= s_we;
      s_oe   <= oe_n;
      s_addr <= addr;
      s_dq   <= dq_in;
    end
  end

  assign ras_lo    = ~s_ras;
  assign ras_fall  = p_ras & ~s_ras;
  assign cas_lo    = ~s_cas;
  assign cas_fall  = p_cas & ~s_cas;
  assign cas_rise  = ~p_cas & s_cas;
  assign col_first = (&p_cas) & ~(&s_cas);
  assign we_lo     = ~s_we;
  assign we_fall   = p_we & ~s_we;
  assign oe_lo     = ~s_oe;
endmodule

// File: rtl/edo_addr_latch.sv
module edo_addr_latch #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_lo,
  input  logic              ras_fall,
  input  logic              col_first,
  input  logic [ADDR_W-1:0] s_addr,
  output logic [ADDR_W-1:0] row_q,
  output logic [ADDR_W-1:0] col_q,
  output logic [ADDR_W-1:0] col_next
);
  logic col_take;

  assign col_take = col_first & ras_lo;
  assign col_next = col_take ? s_addr : col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      if (ras_fall) row_q <= s_addr;
      col_q <= col_next;
    end
  end
endmodule

// File: rtl/edo_lane_fsm.sv
module edo_lane_fsm
  import edo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ras_lo,
  input  logic       cas_lo,
  input  logic       cas_fall,
  input  logic       cas_rise,
  input  logic       we_lo,
  input  logic       we_fall,
  input  logic       oe_lo,
  output lane_mode_e mode_q,
  output logic       early_wr,
  output logic       late_wr
);
  lane_mode_e mode_d;

  always_comb begin
    mode_d   = mode_q;
    early_wr = 1'b0;
    late_wr  = 1'b0;
    if (!ras_lo) begin
      mode_d = LM_IDLE;
    end else if (cas_fall) begin
      if (we_lo) begin
        mode_d   = LM_EARLY;
        early_wr = 1'b1;
      end else begin
        mode_d = LM_READ;
      end
    end else if (mode_q == LM_READ && we_fall) begin
      if (!cas_lo) begin
        mode_d = LM_IDLE;
      end else if (!oe_lo) begin
        mode_d  = LM_LATE;
        late_wr = 1'b1;
      end
      // OE asserted: write dropped, read continues
    end else if (cas_rise && (mode_q == LM_EARLY || mode_q == LM_LATE)) begin
      mode_d = LM_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= LM_IDLE;
    else     mode_q <= mode_d;
  end
endmodule

// File: rtl/edo_word_store.sv
module edo_word_store #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8,
  parameter int IDX_W  = 8
) (
  input  logic                    clk,
  input  logic [IDX_W-1:0]        waddr,
  input  logic [LANES-1:0]        wbe,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [IDX_W-1:0]        raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (wbe[g]) bank[waddr] <= wdata[g*LANE_W +: LANE_W];
      rdata[g*LANE_W +: LANE_W] <= bank[raddr];
    end
  end
endmodule

// File: rtl/edo_lane_ctrl.sv
module edo_lane_ctrl
  import edo_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ras_n,
  input  logic                  casl_n,
  input  logic                  cash_n,
  input  logic                  we_n,
  input  logic                  oe_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [2*LANE_W-1:0]   dq_in,
  output logic [2*LANE_W-1:0]   dq_out,
  output logic [1:0]            dq_oe,
  output logic                  mix_err
);
  localparam int LANES = 2;
  localparam int DQ_W  = LANES * LANE_W;
  localparam int IDX_W = 2 * ADDR_W;

  logic              ras_lo, ras_fall, col_first, we_lo, we_fall, oe_lo;
  logic [LANES-1:0]  cas_lo, cas_fall, cas_rise;
  logic [ADDR_W-1:0] s_addr, row_q, col_q, col_next;
  logic [DQ_W-1:0]   s_dq;
  logic [LANES-1:0]  early_v, late_v, wr_be, oe_q;
  logic              mixed, err_q;
  lane_mode_e [LANES-1:0] lane_mode;

  edo_pin_sampler #(.LANES(LANES), .ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_smp (
    .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n({cash_n, casl_n}),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
    .ras_lo(ras_lo), .ras_fall(ras_fall), .cas_lo(cas_lo),
    .cas_fall(cas_fall), .cas_rise(cas_rise), .col_first(col_first),
    .we_lo(we_lo), .we_fall(we_fall), .oe_lo(oe_lo),
    .s_addr(s_addr), .s_dq(s_dq)
  );

  edo_addr_latch #(.ADDR_W(ADDR_W)) u_adr (
    .clk(clk), .rst(rst), .ras_lo(ras_lo), .ras_fall(ras_fall),
    .col_first(col_first), .s_addr(s_addr),
    .row_q(row_q), .col_q(col_q), .col_next(col_next)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    edo_lane_fsm u_fsm (
      .clk(clk), .rst(rst), .ras_lo(ras_lo), .cas_lo(cas_lo[g]),
      .cas_fall(cas_fall[g]), .cas_rise(cas_rise[g]),
      .we_lo(we_lo), .we_fall(we_fall), .oe_lo(oe_lo),
      .mode_q(lane_mode[g]), .early_wr(early_v[g]), .late_wr(late_v[g])
    );

    always_ff @(posedge clk) begin
      if (rst) oe_q[g] <= 1'b0;
      else     oe_q[g] <= (lane_mode[g] == LM_READ) & oe_lo & ras_lo;
    end
  end

  // one lane early while the other is late in the same cycle is illegal
  assign mixed = (|early_v) & (|late_v);
  assign wr_be = (early_v | late_v) & {LANES{~mixed}};

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= err_q | mixed;
  end

  edo_word_store #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .waddr({row_q, col_next}), .wbe(wr_be), .wdata(s_dq),
    .raddr({row_q, col_q}), .rdata(dq_out)
  );

  assign dq_oe   = oe_q;
  assign mix_err = err_q;
endmodule

// File: rtl/edo_lane_chk.sv
module edo_lane_chk
  import edo_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             ras_lo,
  input lane_mode_e [1:0] lane_mode,
  input logic [1:0]       early_v,
  input logic [1:0]       late_v,
  input logic [1:0]       wr_be,
  input logic [1:0]       dq_oe,
  input logic             mix_err
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dq_oe == 2'b00 && !mix_err));

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (rst)
    mix_err |=> mix_err);

  a_r11_mixed_blocks: assert property (@(posedge clk) disable iff (rst)
    ((|early_v) && (|late_v)) |-> (wr_be == 2'b00));

  a_r11_mixed_flags: assert property (@(posedge clk) disable iff (rst)
    ((|early_v) && (|late_v)) |=> mix_err);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    a_r8_ras_high_idle: assert property (@(posedge clk) disable iff (rst)
      !ras_lo |=> (lane_mode[g] == LM_IDLE));

    a_r5_early_no_drive: assert property (@(posedge clk) disable iff (rst)
      (lane_mode[g] == LM_EARLY) |=> !dq_oe[g]);

    a_r6_write_in_row: assert property (@(posedge clk) disable iff (rst)
      wr_be[g] |-> ras_lo);
  end
endmodule

bind edo_lane_ctrl edo_lane_chk u_chk (
  .clk(clk), .rst(rst), .ras_lo(ras_lo), .lane_mode(lane_mode),
  .early_v(early_v), .late_v(late_v), .wr_be(wr_be),
  .dq_oe(dq_oe), .mix_err(mix_err)
);

// File: tb/tb_edo_lane_ctrl.sv
module tb_edo_lane_ctrl;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ras_n = 1'b1, casl_n = 1'b1, cash_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0]   dq_in = '0;
  logic [15:0]   dq_out;
  logic [1:0]    dq_oe;
  logic          mix_err;
  int            checks = 0;
  int            fails = 0;

  always #5 clk = ~clk;

  edo_lane_ctrl #(.ADDR_W(AW), .LANE_W(8)) dut (
    .clk(clk), .rst(rst), .ras_n(ras_n), .casl_n(casl_n), .cash_n(cash_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .mix_err(mix_err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pins(input logic r, input logic cl, input logic ch, input logic w,
                      input logic o, input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    ras_n = r; casl_n = cl; cash_n = ch; we_n = w; oe_n = o; addr = a; dq_in = d;
    repeat (4) @(negedge clk);
  endtask

  task automatic idle();
    pins(1, 1, 1, 1, 1, '0, '0);
  endtask

  task automatic write_early(input logic [AW-1:0] row, input logic [AW-1:0] col,
                             input logic [15:0] data, input logic [1:0] be);
    pins(0, 1, 1, 1, 1, row, '0);
    pins(0, 1, 1, 0, 0, col, data);
    pins(0, ~be[0], ~be[1], 0, 0, col, data);
    chk("R5 early write keeps lanes undriven", {14'd0, dq_oe}, 16'd0);
    idle();
  endtask

  task automatic read_word(input logic [AW-1:0] row, input logic [AW-1:0] col,
                           output logic [15:0] data, output logic [1:0] oe);
    pins(0, 1, 1, 1, 1, row, '0);
    pins(0, 0, 0, 1, 0, col, '0);
    data = dq_out;
    oe   = dq_oe;
    idle();
  endtask

  task automatic t_reset();
    chk("R1 dq_oe after reset", {14'd0, dq_oe}, 16'd0);
    chk("R1 mix_err after reset", {15'd0, mix_err}, 16'd0);
  endtask

  task automatic t_address();
    logic [15:0] d;
    logic [1:0]  o;
    write_early(4'd1, 4'd2, 16'h1234, 2'b11);
    write_early(4'd2, 4'd1, 16'hABCD, 2'b11);
    read_word(4'd1, 4'd2, d, o);
    chk("R2 read drives both lanes", {14'd0, o}, 16'd3);
    chk("R9 word at row1 col2", d, 16'h1234);
    read_word(4'd2, 4'd1, d, o);
    chk("R9 word at row2 col1", d, 16'hABCD);
  endtask

  task automatic t_edo_hold();
    pins(0, 1, 1, 1, 1, 4'd1, '0);
    pins(0, 0, 0, 1, 0, 4'd2, '0);
    chk("R2 read data", dq_out, 16'h1234);
    pins(0, 1, 1, 1, 0, 4'd2, '0);
    chk("R3 drive held after CAS rise", {14'd0, dq_oe}, 16'd3);
    chk("R3 data held after CAS rise", dq_out, 16'h1234);
    pins(0, 1, 1, 1, 1, 4'd2, '0);
    chk("R4 OE high releases bus", {14'd0, dq_oe}, 16'd0);
    pins(0, 1, 1, 1, 0, 4'd2, '0);
    chk("R4 OE low drives again", {14'd0, dq_oe}, 16'd3);
    chk("R4 data after OE return", dq_out, 16'h1234);
    pins(0, 1, 1, 0, 0, 4'd2, '0);
    chk("R8 WE fall with CAS high releases", {14'd0, dq_oe}, 16'd0);
    idle();
  endtask

  task automatic t_ras_release();
    pins(0, 1, 1, 1, 1, 4'd2, '0);
    pins(0, 0, 0, 1, 0, 4'd1, '0);
    pins(0, 0, 0, 1, 1, 4'd1, '0);
    chk("R4 OE high with CAS low", {14'd0, dq_oe}, 16'd0);
    pins(0, 0, 0, 1, 0, 4'd1, '0);
    chk("R4 OE low with CAS low", {14'd0, dq_oe}, 16'd3);
    chk("R4 data with CAS low", dq_out, 16'hABCD);
    pins(1, 0, 0, 1, 0, 4'd1, '0);
    chk("R8 RAS high releases", {14'd0, dq_oe}, 16'd0);
    idle();
  endtask

  task automatic t_late_write();
    logic [15:0] d;
    logic [1:0]  o;
    write_early(4'd3, 4'd3, 16'h0000, 2'b11);
    pins(0, 1, 1, 1, 1, 4'd3, '0);
    pins(0, 1, 0, 1, 1, 4'd3, 16'h1100);
    pins(0, 1, 0, 0, 1, 4'd3, 16'h5A00);
    idle();
    read_word(4'd3, 4'd3, d, o);
    chk("R6 late write takes data at WE fall", d, 16'h5A00);
    chk("R10 low byte untouched by high lane", {8'd0, d[7:0]}, 16'h0000);
  endtask

  task automatic t_suppressed();
    logic [15:0] d;
    logic [1:0]  o;
    write_early(4'd4, 4'd4, 16'h1111, 2'b11);
    pins(0, 1, 1, 1, 1, 4'd4, '0);
    pins(0, 0, 0, 1, 0, 4'd4, '0);
    pins(0, 0, 0, 0, 0, 4'd4, 16'h2222);
    chk("R7 lanes still drive", {14'd0, dq_oe}, 16'd3);
    chk("R7 old data on bus", dq_out, 16'h1111);
    idle();
    read_word(4'd4, 4'd4, d, o);
    chk("R7 store unchanged", d, 16'h1111);
  endtask

  task automatic t_lane_only();
    logic [15:0] d;
    logic [1:0]  o;
    write_early(4'd1, 4'd2, 16'hEE77, 2'b01);
    read_word(4'd1, 4'd2, d, o);
    chk("R10 low lane write only", d, 16'h1277);
  endtask

  task automatic t_mixed();
    logic [15:0] d;
    logic [1:0]  o;
    write_early(4'd5, 4'd5, 16'h3333, 2'b11);
    chk("R11 no flag on legal traffic", {15'd0, mix_err}, 16'd0);
    pins(0, 1, 1, 1, 1, 4'd5, '0);
    pins(0, 1, 0, 1, 1, 4'd5, '0);
    pins(0, 0, 0, 0, 1, 4'd5, 16'h4444);
    chk("R11 flag set", {15'd0, mix_err}, 16'd1);
    idle();
    read_word(4'd5, 4'd5, d, o);
    chk("R11 neither lane written", d, 16'h3333);
    chk("R11 flag sticky", {15'd0, mix_err}, 16'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_address();
    t_edo_hold();
    t_ras_release();
    t_late_write();
    t_suppressed();
    t_lane_only();
    t_mixed();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule